// File: doc/BRIEF.md
# Six-Control ALU with Gated Carry

This is a 16-bit combinational arithmetic and logic unit. Six control bits set its function. Each operand can first be cleared and then complemented. The two conditioned operands are then either added or combined by bitwise AND, and the result can be complemented at the end. Many useful functions come from this one scheme: constants, pass-through, negation, increment, decrement, sum, difference, AND and OR.

Compared with the plain form of this scheme, the unit has a carry path. A use-carry control decides whether the external carry input reaches the adder; when the control is low, the adder's carry-in is zero. The unit reports the adder's carry-out and flags the final result as zero or negative. Storing the flags, choosing the operands and decoding instructions are left to the surrounding datapath.

Top module: `flagalu`

## Requirements
- R1: ctl[5] (zero-x) forces the x operand to 0 before any inversion; ctl[3] (zero-y) does the same for y.
- R2: ctl[4] (invert-x) complements the x operand after the zero step; ctl[2] (invert-y) does the same for y.
- R3: ctl[1] (function) = 1 adds the conditioned operands (modulo 2^16); ctl[1] = 0 gives their bitwise AND.
- R4: ctl[0] (invert-out) complements the 16-bit function result to form `result`.
- R5: With `carry_en` = 0, `carry_in` has no effect on any output.
- R6: With `carry_en` = 1 and ctl[1] = 1, `carry_in` is added into the sum as the adder's carry-in.
- R7: `carry_out` is the adder's carry out of bit 15 when ctl[1] = 1. It is taken before the output inversion, and it is 0 when ctl[1] = 0.
- R8: `is_zero` is 1 exactly when all 16 bits of `result` are 0.
- R9: `is_neg` equals bit 15 of `result`.
- R10: Controls 101010, 111111 and 111010 (ctl[5] first) give 0, 1 and 16'hFFFF, with no carry enabled.
- R11: Control 001100 passes x unchanged, and control 110000 passes y unchanged.
- R12: Controls 000010, 010011, 000111, 010101, 011111 and 001110 give x+y, x-y, y-x, x OR y, x+1 and x-1, with no carry enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_x | input | 16 | First operand |
| in_y | input | 16 | Second operand |
| ctl | input | 6 | {zero-x, invert-x, zero-y, invert-y, function, invert-out} |
| carry_en | input | 1 | Use-carry control: 1 lets carry_in reach the adder |
| carry_in | input | 1 | External carry input |
| result | output | 16 | Final result |
| carry_out | output | 1 | Adder carry out of bit 15, 0 in AND mode |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Bit 15 of result |

## Verification
The bench sends carry_in = 1 with carry_en low. A unit that ignores the gate returns a result one too large. Subtraction codes are applied to operands that straddle zero and 16'hFFFF. A unit that takes carry_out after the output inversion, or that leaks the adder carry in AND mode, reports the wrong carry on exactly these operands. Every one of the 64 control codes is swept against an independent integer model. Named codes are also compared against fixed results, so a swapped control-bit order, or inversion applied before zeroing, gives a wrong constant or a wrong identity. Results of exactly 0 and 16'h8000 test both flags at their edges.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic fn;
    logic no;
  } alu_ctl_t;

  function automatic logic [15:0] cond_operand(input logic [15:0] v,
                                                input logic zero,
                                                input logic inv);
    logic [15:0] t;
    t = zero ? 16'h0000 : v;
    return inv ? ~t : t;
  endfunction

  function automatic logic [16:0] add_with_carry(input logic [15:0] a,
                                                  input logic [15:0] b,
                                                  input logic cin);
    return {1'b0, a} + {1'b0, b} + {16'h0000, cin};
  endfunction

endpackage

// File: rtl/flagalu_operand.sv
module flagalu_operand #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] raw,
  input  logic             zero_en,
  input  logic             inv_en,
  output logic [WIDTH-1:0] cond
);
  logic [WIDTH-1:0] zeroed;

  always_comb begin
    zeroed = zero_en ? '0 : raw;
    cond   = inv_en ? ~zeroed : zeroed;
  end

  always_comb begin
    if (zero_en && !inv_en)
      AST_ZERO_FIRST: assert (cond == '0) else $error("zero step not applied"); // R1
    if (zero_en && inv_en)
      AST_INV_AFTER_ZERO: assert (&cond) else $error("invert not after zero"); // R2
  end
endmodule

// File: rtl/flagalu_core.sv
module flagalu_core #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opx,
  input  logic [WIDTH-1:0] opy,
  input  logic             fn_add,
  input  logic             carry_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] fn_out,
  output logic             adder_cin,
  output logic             carry_out
);
  logic [WIDTH:0]   sum_ext;
  logic [WIDTH-1:0] and_val;

  always_comb begin
    adder_cin = carry_en & carry_in;
    sum_ext   = {1'b0, opx} + {1'b0, opy} + {{WIDTH{1'b0}}, adder_cin};
    and_val   = opx & opy;
    fn_out    = fn_add ? sum_ext[WIDTH-1:0] : and_val;
    carry_out = fn_add & sum_ext[WIDTH];
  end

  always_comb begin
    if (!carry_en)
      AST_CIN_GATED: assert (adder_cin == 1'b0) else $error("carry leaked"); // R5
    if (!fn_add)
      AST_AND_NO_CARRY: assert (carry_out == 1'b0) else $error("carry in AND"); // R7
  end
endmodule

// File: rtl/flagalu_result.sv
module flagalu_result #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] fn_out,
  input  logic             inv_out,
  output logic [WIDTH-1:0] result,
  output logic             is_zero,
  output logic             is_neg
);
  always_comb begin
    result  = inv_out ? ~fn_out : fn_out;
    is_zero = (result == '0);
    is_neg  = result[WIDTH-1];
  end

  always_comb begin
    AST_ZERO_NOT_NEG: assert (!(is_zero && is_neg)) else $error("flags clash"); // R8
    if (inv_out)
      AST_OUT_INVERTED: assert ((result ^ fn_out) == '1) else $error("no inversion"); // R4
  end
endmodule

// File: rtl/flagalu.sv
module flagalu
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_x,
  input  logic [WIDTH-1:0] in_y,
  input  logic [5:0]       ctl,
  input  logic             carry_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             is_zero,
  output logic             is_neg
);
  alu_ctl_t         c;
  logic [WIDTH-1:0] opx;
  logic [WIDTH-1:0] opy;
  logic [WIDTH-1:0] fn_out;
  logic             adder_cin;

  assign c = alu_ctl_t'(ctl);

  flagalu_operand #(.WIDTH(WIDTH)) u_opx (
    .raw(in_x), .zero_en(c.zx), .inv_en(c.nx), .cond(opx));

  flagalu_operand #(.WIDTH(WIDTH)) u_opy (
    .raw(in_y), .zero_en(c.zy), .inv_en(c.ny), .cond(opy));

  flagalu_core #(.WIDTH(WIDTH)) u_core (
    .opx(opx), .opy(opy), .fn_add(c.fn), .carry_en(carry_en),
    .carry_in(carry_in), .fn_out(fn_out), .adder_cin(adder_cin),
    .carry_out(carry_out));

  flagalu_result #(.WIDTH(WIDTH)) u_res (
    .fn_out(fn_out), .inv_out(c.no), .result(result),
    .is_zero(is_zero), .is_neg(is_neg));

  always_comb begin
    if (carry_en && c.fn)
      AST_CIN_USED: assert (adder_cin == carry_in) else $error("carry not used"); // R6
    if (c.no)
      AST_ZERO_ALL_ONES_RAW: assert (is_zero == (&fn_out)) else $error("zero flag"); // R8
    AST_NEG_BIT: assert (is_neg == (c.no ^ fn_out[WIDTH-1])) else $error("neg flag"); // R9
  end
endmodule

// File: tb/flagalu_test.sv
module flagalu_test;
  logic        clk = 1'b0;
  logic [15:0] in_x = '0, in_y = '0;
  logic [5:0]  ctl = '0;
  logic        carry_en = 1'b0, carry_in = 1'b0;
  logic [15:0] result;
  logic        carry_out, is_zero, is_neg;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        co, z, n;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  flagalu uut (.in_x(in_x), .in_y(in_y), .ctl(ctl), .carry_en(carry_en),
               .carry_in(carry_in), .result(result), .carry_out(carry_out),
               .is_zero(is_zero), .is_neg(is_neg));

  // Independent integer model written from the requirements
  function automatic exp_t model(int x, int y, int code, bit ce, bit ci);
    exp_t e;
    int a, b, r, co;
    a = code[5] ? 0 : x;
    if (code[4]) a = 65535 - a;
    b = code[3] ? 0 : y;
    if (code[2]) b = 65535 - b;
    if (code[1]) begin
      r  = a + b + ((ce && ci) ? 1 : 0);
      co = r / 65536;
      r  = r % 65536;
    end else begin
      r  = a & b;
      co = 0;
    end
    if (code[0]) r = 65535 - r;
    e.res = r[15:0];
    e.co  = co[0];
    e.z   = (r == 0);
    e.n   = (r >= 32768);
    return e;
  endfunction

  task automatic drive(input logic [15:0] x, input logic [15:0] y,
                       input logic [5:0] code, input bit ce, input bit ci,
                       input string req, input bit fixed, input logic [15:0] fval);
    exp_t e;
    @(posedge clk);
    in_x = x; in_y = y; ctl = code; carry_en = ce; carry_in = ci;
    e = model(int'(x), int'(y), int'(code), ce, ci);
    e.req = req;
    if (fixed) begin
      e.res = fval;
      e.z   = (fval == 16'h0);
      e.n   = fval[15];
    end
    sb.push_back(e);
  endtask

  // Monitor: compares away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (result !== e.res || carry_out !== e.co || is_zero !== e.z || is_neg !== e.n) begin
          errors++;
          $display("FAIL %s: got res=%h co=%b z=%b n=%b exp res=%h co=%b z=%b n=%b",
                   e.req, result, carry_out, is_zero, is_neg, e.res, e.co, e.z, e.n);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // idle pattern: all-zero inputs, AND mode -> 0, zero flag set (R8)
    drive(16'h0, 16'h0, 6'b000000, 0, 0, "R8_idle", 1, 16'h0000);
    // R10 constants, carry_in high but gated off also covers R5
    drive(16'h1234, 16'hABCD, 6'b101010, 0, 1, "R10_zero_R5", 1, 16'h0000);
    drive(16'h1234, 16'hABCD, 6'b111111, 0, 1, "R10_one", 1, 16'h0001);
    drive(16'h1234, 16'hABCD, 6'b111010, 0, 0, "R10_minus1_R9", 1, 16'hFFFF);
    // R11 identities
    drive(16'h8001, 16'h7777, 6'b001100, 0, 0, "R11_passx", 1, 16'h8001);
    drive(16'h8001, 16'h7777, 6'b110000, 0, 0, "R11_passy", 1, 16'h7777);
    // R12 arithmetic codes
    drive(16'h0005, 16'h0003, 6'b000010, 0, 0, "R12_add", 1, 16'h0008);
    drive(16'h0003, 16'h0005, 6'b010011, 0, 0, "R12_xminusy", 1, 16'hFFFE);
    drive(16'h0003, 16'h0005, 6'b000111, 0, 0, "R12_yminusx", 1, 16'h0002);
    drive(16'hF000, 16'h00F0, 6'b010101, 0, 0, "R12_or", 1, 16'hF0F0);
    drive(16'hFFFF, 16'h0000, 6'b011111, 0, 0, "R12_inc_wrap_R8", 1, 16'h0000);
    drive(16'h0000, 16'h0000, 6'b001110, 0, 0, "R12_dec_zero_R7", 1, 16'hFFFF);
    drive(16'h0001, 16'h0000, 6'b001110, 0, 0, "R12_dec_one_R7", 1, 16'h0000);
    // R6 carry used, R5 carry ignored
    drive(16'hFFFF, 16'h0000, 6'b000010, 1, 1, "R6_cin_wrap", 1, 16'h0000);
    drive(16'h0010, 16'h0020, 6'b000010, 1, 1, "R6_cin_add", 1, 16'h0031);
    drive(16'h0010, 16'h0020, 6'b000010, 0, 1, "R5_cin_ignored", 1, 16'h0030);
    // R7 carry before output inversion, none in AND mode
    drive(16'h8000, 16'h8000, 6'b000011, 0, 0, "R7_carry_inverted", 1, 16'hFFFF);
    drive(16'hFFFF, 16'hFFFF, 6'b000001, 1, 1, "R7_and_nocarry", 1, 16'h0000);
    // R9 sign boundary
    drive(16'h7FFF, 16'h0001, 6'b000010, 0, 0, "R9_signflip", 1, 16'h8000);
    // R1 R2 R3 R4 full code sweep against the model
    for (int k = 0; k < 64; k++) begin
      for (int j = 0; j < 4; j++) begin
        logic [15:0] xv, yv;
        xv = (j == 0) ? 16'h0000 : (j == 1) ? 16'hFFFF : 16'($urandom);
        yv = (j == 2) ? 16'h8000 : 16'($urandom);
        drive(xv, yv, 6'(k), 1'(j[0]), 1'($urandom), "R1_R2_R3_R4_sweep", 0, 16'h0);
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule